// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block sits inside a board-control FPGA and gathers thirty-two level-sensitive interrupt requests from board peripherals into one active-low, level-type interrupt line toward the host processor. The host reaches it through a simple synchronous 16-bit register port. Each source has one status bit and one mask bit. The sources are split into a lower half (sources 0 to 15) and an upper half (sources 16 to 31). A mask bit set to 1 blocks its source. The host forms the 32-bit pending word as status AND NOT mask, with the upper half in bits 31:16. It then services every pending bit. Source 15 of the lower half carries the Ethernet controller's request.

The same register port also reaches two more registers. One is a read-only revision word: the processor-board revision is in the high byte and the base-board revision is in the low byte. The other is a device-reset control register. Its bit 2 drives the Ethernet controller's reset. Every source input passes through a synchroniser before it reaches the status registers. The interrupt line comes from a flop, so it never glitches.

Top module: `irq_gather_top`

## Requirements
- R1: Reading offset 0x0020 returns the synchronised levels of sources 0..15, and reading offset 0x0022 returns sources 16..31. In both registers, bit n is source n of that half.
- R2: The mask registers at offset 0x0030 (sources 0..15) and offset 0x0032 (sources 16..31) can be written and read back. Both reset to 0xFFFF.
- R3: The interrupt output irqN is low exactly when some source has its status bit at 1 and its mask bit at 0. A mask bit at 1 keeps its source from lowering irqN.
- R4: irqN is high while reset is asserted and after reset is released.
- R5: A change on a source input shows in the status register two clock edges later, and reaches irqN one edge after that. A mask write changes irqN on the edge after the write edge.
- R6: Reading offset 0x1100 returns {CPU_REV, BASE_REV}, with CPU_REV in bits 15:8. Writes to this offset change nothing.
- R7: The device-reset register at offset 0x10D0 resets to 0x0000 and can be written and read back. Output ethRst follows its bit 2 from the edge after the write.
- R8: Writes to the status offsets 0x0020 and 0x0022 leave the status values unchanged.
- R9: A read of any unmapped offset returns 0x0000. A write to an unmapped offset changes no register and does not change irqN.
- R10: busRdData takes the selected value on the edge that samples busRdEn. It is 0x0000 after any edge at which busRdEn was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port and logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 13 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Registered read data |
| irqSrc | input | 32 | Level-sensitive interrupt requests, active high |
| irqN | output | 1 | Combined interrupt to the host, active low |
| ethRst | output | 1 | Ethernet controller reset, from device-reset bit 2 |

## Verification
The bench builds the block with the default 16-bit registers, 32 sources and a two-stage synchroniser. It overrides the revision parameters to 0xA5 and 0x3C, so that a byte swap in the revision word shows up as a wrong value. Keeping the default synchroniser depth makes the three-edge path from a source to irqN observable edge by edge. Sources are set in both halves, so that a swap of the two halves, or of the status and mask meaning, changes both the read values and the level of irqN.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

  // Byte offsets on the register port
  localparam int unsigned OFS_STAT_LO = 32'h0020;
  localparam int unsigned OFS_STAT_HI = 32'h0022;
  localparam int unsigned OFS_MASK_LO = 32'h0030;
  localparam int unsigned OFS_MASK_HI = 32'h0032;
  localparam int unsigned OFS_DEVRST  = 32'h10D0;
  localparam int unsigned OFS_VERSION = 32'h1100;

  // Bit of the device-reset register wired to the Ethernet controller reset
  localparam int unsigned ETH_RST_BIT = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT_LO,
    RD_STAT_HI,
    RD_MASK_LO,
    RD_MASK_HI,
    RD_DEVRST,
    RD_VERSION
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   wrMaskLo;
    logic   wrMaskHi;
    logic   wrDevRst;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           strobe
);

  logic hitStatLo, hitStatHi, hitMaskLo, hitMaskHi, hitDevRst, hitVersion;

  assign hitStatLo  = (busAddr == ADDR_W'(OFS_STAT_LO));
  assign hitStatHi  = (busAddr == ADDR_W'(OFS_STAT_HI));
  assign hitMaskLo  = (busAddr == ADDR_W'(OFS_MASK_LO));
  assign hitMaskHi  = (busAddr == ADDR_W'(OFS_MASK_HI));
  assign hitDevRst  = (busAddr == ADDR_W'(OFS_DEVRST));
  assign hitVersion = (busAddr == ADDR_W'(OFS_VERSION));

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    strobe.rdEn     = busRdEn;
    // Status and version offsets take no write strobe
    strobe.wrMaskLo = busWrEn && hitMaskLo;
    strobe.wrMaskHi = busWrEn && hitMaskHi;
    strobe.wrDevRst = busWrEn && hitDevRst;
    if (hitStatLo)       strobe.rdSel = RD_STAT_LO;
    else if (hitStatHi)  strobe.rdSel = RD_STAT_HI;
    else if (hitMaskLo)  strobe.rdSel = RD_MASK_LO;
    else if (hitMaskHi)  strobe.rdSel = RD_MASK_HI;
    else if (hitDevRst)  strobe.rdSel = RD_DEVRST;
    else if (hitVersion) strobe.rdSel = RD_VERSION;
  end

endmodule

// File: rtl/irq_gather_dp.sv
module irq_gather_dp
  import irq_gather_pkg::*;
#(
  parameter int          REG_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CPU_REV     = 8'h01,
  parameter logic [7:0]  BASE_REV    = 8'h01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [REG_W-1:0]     busWrData,
  input  logic [2*REG_W-1:0]   irqSrc,
  output logic [REG_W-1:0]     busRdData,
  output logic                 irqN,
  output logic                 ethRst
);

  localparam int NUM_SRC = 2 * REG_W;
  localparam int REV_W   = REG_W / 2;

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [REG_W-1:0] statusLo, statusHi;
  logic [REG_W-1:0] maskLo, maskHi;
  logic [REG_W-1:0] devRst;
  logic [NUM_SRC-1:0] pendVec;
  logic [REG_W-1:0] rdMux;

  // Synchroniser chain per source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= irqSrc;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign statusLo = syncQ[SYNC_STAGES-1][REG_W-1:0];
  assign statusHi = syncQ[SYNC_STAGES-1][NUM_SRC-1:REG_W];

  // Mask and device-reset registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLo <= '1;
      maskHi <= '1;
      devRst <= '0;
    end else begin
      if (strobe.wrMaskLo) maskLo <= busWrData;
      if (strobe.wrMaskHi) maskHi <= busWrData;
      if (strobe.wrDevRst) devRst <= busWrData;
    end
  end

  assign ethRst  = devRst[ETH_RST_BIT];
  assign pendVec = {statusHi, statusLo} & ~{maskHi, maskLo};

  // Registered, active-low combined interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~(|pendVec);
  end

  always_comb begin
    case (strobe.rdSel)
      RD_STAT_LO: rdMux = statusLo;
      RD_STAT_HI: rdMux = statusHi;
      RD_MASK_LO: rdMux = maskLo;
      RD_MASK_HI: rdMux = maskHi;
      RD_DEVRST:  rdMux = devRst;
      RD_VERSION: rdMux = {CPU_REV[REV_W-1:0], BASE_REV[REV_W-1:0]};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdData <= '0;
    else if (strobe.rdEn) busRdData <= rdMux;
    else                  busRdData <= '0;
  end

endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top
  import irq_gather_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         REG_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CPU_REV     = 8'h01,
  parameter logic [7:0] BASE_REV    = 8'h01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [REG_W-1:0]     busWrData,
  output logic [REG_W-1:0]     busRdData,
  input  logic [2*REG_W-1:0]   irqSrc,
  output logic                 irqN,
  output logic                 ethRst
);

  strobe_t strobe;

  irq_gather_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  irq_gather_dp #(
    .REG_W       (REG_W),
    .SYNC_STAGES (SYNC_STAGES),
    .CPU_REV     (CPU_REV),
    .BASE_REV    (BASE_REV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .irqSrc    (irqSrc),
    .busRdData (busRdData),
    .irqN      (irqN),
    .ethRst    (ethRst)
  );

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
  import irq_gather_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter int         REG_W    = 16,
  parameter logic [7:0] CPU_REV  = 8'h01,
  parameter logic [7:0] BASE_REV = 8'h01
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [REG_W-1:0]     busWrData,
  input logic [REG_W-1:0]     busRdData,
  input logic [2*REG_W-1:0]   irqSrc,
  input logic                 irqN,
  input logic                 ethRst,
  input logic [REG_W-1:0]     maskLo,
  input logic [REG_W-1:0]     maskHi,
  input logic [REG_W-1:0]     statusLo,
  input logic [REG_W-1:0]     statusHi
);

  logic [1:0] sinceRst;
  logic       anyPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign anyPend = |({statusHi, statusLo} & ~{maskHi, maskLo});

  assert_pend_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |=> !irqN);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    !anyPend |=> irqN);

  assert_reset_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> irqN);

  assert_sync_lat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> ({statusHi, statusLo} == $past(irqSrc, 2)));

  assert_mask_lo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_MASK_LO)) |=> (maskLo == $past(busWrData)));

  assert_mask_hi_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_MASK_HI)) |=> (maskHi == $past(busWrData)));

  assert_version_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(OFS_VERSION)) |=> (busRdData == {CPU_REV, BASE_REV}));

  assert_eth_rst_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_DEVRST)) |=> (ethRst == $past(busWrData[ETH_RST_BIT])));

  assert_idle_rd_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));

endmodule

bind irq_gather_top irq_gather_chk #(
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W),
  .CPU_REV  (CPU_REV),
  .BASE_REV (BASE_REV)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqSrc    (irqSrc),
  .irqN      (irqN),
  .ethRst    (ethRst),
  .maskLo    (u_dp.maskLo),
  .maskHi    (u_dp.maskHi),
  .statusLo  (u_dp.statusLo),
  .statusHi  (u_dp.statusHi)
);

// File: tb/irq_gather_top_bench.sv
module irq_gather_top_bench;

  localparam int ADDR_W = 13;
  localparam int REG_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [REG_W-1:0]  busWrData = '0;
  logic [REG_W-1:0]  busRdData;
  logic [31:0]       irqSrc = '0;
  logic              irqN;
  logic              ethRst;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } rdItem_t;

  rdItem_t expQ[$];

  always #4 clk = ~clk;

  irq_gather_top #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .SYNC_STAGES(2),
    .CPU_REV(8'hA5), .BASE_REV(8'h3C)
  ) u_irq_gather_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqSrc(irqSrc), .irqN(irqN), .ethRst(ethRst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Driver: issues a read and queues the expected word
  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag);
    rdItem_t it;
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // Monitor: compares read data on the edge that samples the strobe
  always @(posedge clk) begin
    logic took;
    rdItem_t it;
    took = busRdEn;
    #2;
    if (took) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read actual=%h expected=none", busRdData);
      end else begin
        it = expQ.pop_front();
        check(it.tag, {16'h0, busRdData}, {16'h0, it.exp});
      end
    end
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 irqN in reset", irqN, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 irqN after reset", irqN, 1);
    check("R7 ethRst reset", ethRst, 0);
    busRead(13'h0030, 16'hFFFF, "R2 mask lo reset");
    busRead(13'h0032, 16'hFFFF, "R2 mask hi reset");
    busRead(13'h10D0, 16'h0000, "R7 devrst reset");

    // Sources in both halves, everything masked
    irqSrc = 32'h8001_0005;
    repeat (3) @(negedge clk);
    busRead(13'h0020, 16'h0005, "R1 status lo");
    busRead(13'h0022, 16'h8001, "R1 status hi");
    check("R3 all masked", irqN, 1);

    // R5 latency from source to irqN through lower bit 15
    busWrite(13'h0030, 16'h7FFF);
    busRead(13'h0030, 16'h7FFF, "R2 mask lo readback");
    check("R3 unmasked but idle", irqN, 1);
    @(negedge clk); irqSrc[15] = 1'b1;
    @(negedge clk); check("R5 edge1", irqN, 1);
    @(negedge clk); check("R5 edge2", irqN, 1);
    @(negedge clk); check("R5 edge3", irqN, 0);
    busRead(13'h0020, 16'h8005, "R1 status lo bit15");

    // R5 mask write takes effect one edge later
    busWrite(13'h0030, 16'hFFFF);
    check("R5 mask edge0", irqN, 0);
    @(negedge clk); check("R3 remasked", irqN, 1);

    // Upper half source 16
    busWrite(13'h0032, 16'hFFFE);
    @(negedge clk); check("R3 upper source", irqN, 0);
    busRead(13'h0032, 16'hFFFE, "R2 mask hi readback");
    busWrite(13'h0032, 16'hFFFF);
    @(negedge clk); check("R3 upper remasked", irqN, 1);

    // R8 writes to status offsets
    busWrite(13'h0020, 16'h0000);
    busWrite(13'h0022, 16'hFFFF);
    busRead(13'h0020, 16'h8005, "R8 status lo after write");
    busRead(13'h0022, 16'h8001, "R8 status hi after write");

    // R6 version
    busRead(13'h1100, 16'hA53C, "R6 version");
    busWrite(13'h1100, 16'h0000);
    busRead(13'h1100, 16'hA53C, "R6 version after write");

    // R7 device reset
    busWrite(13'h10D0, 16'h0004);
    check("R7 ethRst set", ethRst, 1);
    busRead(13'h10D0, 16'h0004, "R7 devrst readback");
    busWrite(13'h10D0, 16'h0000);
    check("R7 ethRst clear", ethRst, 0);

    // R9 unmapped offsets: zero writes would unmask if aliased
    busWrite(13'h0034, 16'h0000);
    busWrite(13'h0040, 16'h0000);
    busWrite(13'h1000, 16'h0000);
    @(negedge clk); check("R9 irqN after unmapped writes", irqN, 1);
    busRead(13'h0030, 16'hFFFF, "R9 mask lo kept");
    busRead(13'h0032, 16'hFFFF, "R9 mask hi kept");
    busRead(13'h0040, 16'h0000, "R9 unmapped read");
    busRead(13'h0024, 16'h0000, "R9 unmapped read near status");

    // R10 idle read data
    @(negedge clk); @(negedge clk);
    check("R10 idle rdData", busRdData, 0);

    // Source release clears the interrupt
    busWrite(13'h0030, 16'h7FFF);
    @(negedge clk); check("R3 pending again", irqN, 0);
    irqSrc[15] = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 release after three edges", irqN, 1);

    repeat (3) @(negedge clk);
    check("R10 queue drained", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule